// File: doc/BRIEF.md
# Processor status flag register

This block is the status word of a small CPU core. It keeps eight single-bit flags and a 3-bit interrupt priority level. The flags are carry, zero, interrupt-disable, decimal mode, index length, data length, overflow and negative. The block presents them as a 16-bit word whose top five bits are always zero. Flags change in four ways:

- from ALU results, which update zero, negative, carry and overflow;
- from masked set-flag and clear-flag commands, plus a dedicated set-interrupt-disable command and a dedicated clear-carry command;
- automatically when an interrupt is accepted;
- from a full-word restore, used when the word is popped from the stack.

The block also decides whether a pending interrupt may proceed. A maskable request is held back while interrupt-disable is 1. The four non-maskable classes are always let through: address match, NMI, watchdog and divide-by-zero. The index-length, data-length and decimal-mode flags are exported as mode outputs for the datapath.

Top module: `psr_status_reg`

## Requirements
- R1: `ps_word` is laid out as carry bit 0, zero bit 1, interrupt-disable bit 2, decimal bit 3, index-length bit 4, data-length bit 5, overflow bit 6, negative bit 7, and priority level in bits 10..8. Bits 15..11 always read 0, including after a load whose value has those bits set.
- R2: A clock edge with `rst_n` low sets interrupt-disable to 1. The same edge clears decimal, index-length, data-length, overflow, negative and the priority level to 0. Carry and zero are left without a defined value.
- R3: With `alu_nz_en`, zero takes "result is all zero" and negative takes the result's top bit. The width is 8 bits (bits 7..0) when data-length is 1 and 16 bits when it is 0. With `alu_c_en`, carry takes `alu_carry`. With `alu_v_en`, overflow takes `alu_ovf`. Each update is visible after the next clock edge.
- R4: With `set_en`, every bit set in `flag_mask` sets the flag at the same bit position (0..7). With `clr_en`, every such bit clears that flag. For one flag, set beats clear, and both beat an ALU update in the same cycle.
- R5: `sei_cmd` sets interrupt-disable and `clc_cmd` clears carry, with the same ordering as R4.
- R6: `irq_accept` forces interrupt-disable to 1 at the next edge, even if a clear of that flag is commanded in the same cycle.
- R7: `load_en` writes `load_val[10:0]` into the register. It overrides every other update in that cycle, including `irq_accept`.
- R8: `irq_go` is 1 when any bit of `irq_nm_req` is 1. Otherwise it equals `irq_mreq` while interrupt-disable is 0, and it is 0 while interrupt-disable is 1. This output is combinational from the current register value.
- R9: `idx8_mode` equals the index-length flag, `data8_mode` equals the data-length flag, and `dec_mode` equals the decimal flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| alu_nz_en | input | 1 | Update zero and negative from `alu_result` |
| alu_result | input | DATA_W | ALU result bus |
| alu_c_en | input | 1 | Update carry from `alu_carry` |
| alu_carry | input | 1 | ALU carry, borrow or shifted-out bit |
| alu_v_en | input | 1 | Update overflow from `alu_ovf` |
| alu_ovf | input | 1 | ALU overflow |
| set_en | input | 1 | Set the flags selected by `flag_mask` |
| clr_en | input | 1 | Clear the flags selected by `flag_mask` |
| flag_mask | input | 8 | Flag selection for set/clear, bit n selects flag n |
| sei_cmd | input | 1 | Set interrupt-disable |
| clc_cmd | input | 1 | Clear carry |
| irq_accept | input | 1 | An interrupt is being accepted this cycle |
| load_en | input | 1 | Restore the whole register |
| load_val | input | 16 | Restore value, bits 15..11 ignored |
| irq_mreq | input | 1 | Maskable interrupt request pending |
| irq_nm_req | input | NM_W | Non-maskable request classes (address match, NMI, watchdog, divide-by-zero) |
| ps_word | output | 16 | Status word |
| idx8_mode | output | 1 | Index registers are 8 bits wide |
| data8_mode | output | 1 | Data operations are 8 bits wide |
| dec_mode | output | 1 | Decimal arithmetic selected |
| irq_go | output | 1 | Pending interrupt is allowed through |

## Verification
The clocked assertions take reset as a synchronous level sampled at the edge, and they treat carry and zero as unknown until first written. Any check of those two bits is therefore made only in cycles that follow a write of them. The set-mask check assumes that no restore is commanded in the same cycle. The clear-mask check also excludes a simultaneous set or restore. The stimulus drives each command for a single cycle between falling edges and returns all inputs to zero afterwards. It never compares carry or zero before a load, an ALU update or a set/clear has defined them.

// File: rtl/psr_pkg.sv
// Package: field positions and sizes of the processor status word.
// Assumes a 16-bit visible word with an 11-bit implemented register.
package psr_pkg;
    localparam int WORD_W  = 16;
    localparam int PS_W    = 11;
    localparam int LOW_W   = 8;
    localparam int IPL_W   = 3;
    localparam int IPL_LSB = 8;
    localparam int B_C = 0;
    localparam int B_Z = 1;
    localparam int B_I = 2;
    localparam int B_D = 3;
    localparam int B_X = 4;
    localparam int B_M = 5;
    localparam int B_V = 6;
    localparam int B_N = 7;
endpackage

// File: rtl/psr_flag_next.sv
// Computes the next value of the implemented status bits from the current
// value and every update source, applying the fixed priority
// ALU < clear < set < interrupt acceptance < full load.
// Assumes all inputs are stable before the clock edge; purely combinational.
module psr_flag_next
    import psr_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [PS_W-1:0]   cur,
    input  logic              alu_nz_en,
    input  logic [DATA_W-1:0] alu_result,
    input  logic              alu_c_en,
    input  logic              alu_carry,
    input  logic              alu_v_en,
    input  logic              alu_ovf,
    input  logic              set_en,
    input  logic              clr_en,
    input  logic [LOW_W-1:0]  flag_mask,
    input  logic              sei_cmd,
    input  logic              clc_cmd,
    input  logic              irq_accept,
    input  logic              load_en,
    input  logic [WORD_W-1:0] load_val,
    output logic [PS_W-1:0]   nxt
);
    localparam int HALF_W = DATA_W / 2;

    logic [LOW_W-1:0] alu_low;
    logic [LOW_W-1:0] set_vec;
    logic [LOW_W-1:0] clr_vec;
    logic [LOW_W-1:0] cmd_low;
    logic             res_zero;
    logic             res_neg;
    logic             unused_load_hi;

    assign unused_load_hi = ^load_val[WORD_W-1:PS_W];

    // Zero and negative detection at the width chosen by the data-length flag.
    always_comb begin
        if (cur[B_M]) begin
            res_zero = (alu_result[HALF_W-1:0] == '0);
            res_neg  = alu_result[HALF_W-1];
        end else begin
            res_zero = (alu_result == '0);
            res_neg  = alu_result[DATA_W-1];
        end
    end

    // ALU-driven flag updates applied to the current low byte.
    always_comb begin
        alu_low = cur[LOW_W-1:0];
        if (alu_nz_en) begin
            alu_low[B_Z] = res_zero;
            alu_low[B_N] = res_neg;
        end
        if (alu_c_en) alu_low[B_C] = alu_carry;
        if (alu_v_en) alu_low[B_V] = alu_ovf;
    end

    // Build the set and clear vectors from masks and dedicated commands.
    always_comb begin
        set_vec = set_en ? flag_mask : '0;
        clr_vec = clr_en ? flag_mask : '0;
        if (sei_cmd) set_vec[B_I] = 1'b1;
        if (clc_cmd) clr_vec[B_C] = 1'b1;
    end

    // Per-flag arbitration: set beats clear beats ALU.
    for (genvar b = 0; b < LOW_W; b++) begin : g_flag
        assign cmd_low[b] = set_vec[b] ? 1'b1 : (clr_vec[b] ? 1'b0 : alu_low[b]);
    end

    // Final selection: load overrides everything, acceptance forces disable.
    always_comb begin
        if (load_en) begin
            nxt = load_val[PS_W-1:0];
        end else begin
            nxt = {cur[PS_W-1:IPL_LSB], cmd_low};
            if (irq_accept) nxt[B_I] = 1'b1;
        end
    end
endmodule

// File: rtl/psr_irq_gate.sv
// Lets a maskable interrupt request through only while interrupt-disable is
// clear; any non-maskable class request always passes.
// Assumes requests are levels held by the interrupt controller.
module psr_irq_gate #(
    parameter int NM_W = 4
) (
    input  logic            i_flag,
    input  logic            irq_mreq,
    input  logic [NM_W-1:0] irq_nm_req,
    output logic            irq_go
);
    // Combine the gated maskable request with the unmasked classes.
    assign irq_go = (irq_mreq & ~i_flag) | (|irq_nm_req);

    always_comb begin
        if (|irq_nm_req) AST_NM_PASSES: assert (irq_go); // R8
        if (i_flag && !(|irq_nm_req)) AST_MASK_BLOCKS: assert (!irq_go); // R8
    end
endmodule

// File: rtl/psr_status_reg.sv
// Processor status register top: holds the flags and priority level,
// exports the mode bits and gates interrupt requests.
// Assumes synchronous active-low reset; carry and zero are deliberately
// left without reset and stay undefined until first written.
module psr_status_reg
    import psr_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int NM_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alu_nz_en,
    input  logic [DATA_W-1:0] alu_result,
    input  logic              alu_c_en,
    input  logic              alu_carry,
    input  logic              alu_v_en,
    input  logic              alu_ovf,
    input  logic              set_en,
    input  logic              clr_en,
    input  logic [LOW_W-1:0]  flag_mask,
    input  logic              sei_cmd,
    input  logic              clc_cmd,
    input  logic              irq_accept,
    input  logic              load_en,
    input  logic [WORD_W-1:0] load_val,
    input  logic              irq_mreq,
    input  logic [NM_W-1:0]   irq_nm_req,
    output logic [WORD_W-1:0] ps_word,
    output logic              idx8_mode,
    output logic              data8_mode,
    output logic              dec_mode,
    output logic              irq_go
);
    localparam int PAD_W = WORD_W - PS_W;

    logic [PS_W-1:0] ps_q;
    logic [PS_W-1:0] ps_d;

    psr_flag_next #(.DATA_W(DATA_W)) i_next (
        .cur        (ps_q),
        .alu_nz_en  (alu_nz_en),
        .alu_result (alu_result),
        .alu_c_en   (alu_c_en),
        .alu_carry  (alu_carry),
        .alu_v_en   (alu_v_en),
        .alu_ovf    (alu_ovf),
        .set_en     (set_en),
        .clr_en     (clr_en),
        .flag_mask  (flag_mask),
        .sei_cmd    (sei_cmd),
        .clc_cmd    (clc_cmd),
        .irq_accept (irq_accept),
        .load_en    (load_en),
        .load_val   (load_val),
        .nxt        (ps_d)
    );

    // Carry and zero: no reset term, their value is undefined after reset.
    always_ff @(posedge clk) begin
        ps_q[B_Z:B_C] <= ps_d[B_Z:B_C];
    end

    // Remaining flags and priority level with their reset values.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ps_q[PS_W-1:B_I] <= '0;
            ps_q[B_I]        <= 1'b1;
        end else begin
            ps_q[PS_W-1:B_I] <= ps_d[PS_W-1:B_I];
        end
    end

    assign ps_word    = {{PAD_W{1'b0}}, ps_q};
    assign idx8_mode  = ps_q[B_X];
    assign data8_mode = ps_q[B_M];
    assign dec_mode   = ps_q[B_D];

    psr_irq_gate #(.NM_W(NM_W)) i_gate (
        .i_flag     (ps_q[B_I]),
        .irq_mreq   (irq_mreq),
        .irq_nm_req (irq_nm_req),
        .irq_go     (irq_go)
    );

    AST_RESET_VALUES: assert property (@(posedge clk)
        !rst_n |=> (ps_word[B_I] && !ps_word[B_D] && !ps_word[B_X] && !ps_word[B_M])); // R2
    AST_ACCEPT_SETS_I: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_accept && !load_en) |=> ps_word[B_I]); // R6
    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> (ps_word[PS_W-1:0] == $past(load_val[PS_W-1:0]))); // R7
    AST_SET_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (set_en && !load_en) |=> ((ps_word[LOW_W-1:0] & $past(flag_mask)) == $past(flag_mask))); // R4
    AST_CLR_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && !set_en && !sei_cmd && !irq_accept && !load_en)
        |=> ((ps_word[LOW_W-1:0] & $past(flag_mask)) == '0)); // R4
endmodule

// File: tb/test_psr_status_reg.sv
`timescale 1ns/1ps
// Scoreboard bench: the step task applies one cycle of stimulus, updates a
// requirement-level model and queues the expected word; a monitor compares.
module test_psr_status_reg;
    localparam int DW = 16;
    localparam int NW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic alu_nz_en = 0, alu_c_en = 0, alu_carry = 0, alu_v_en = 0, alu_ovf = 0;
    logic [DW-1:0] alu_result = '0;
    logic set_en = 0, clr_en = 0, sei_cmd = 0, clc_cmd = 0, irq_accept = 0, load_en = 0;
    logic [7:0] flag_mask = '0;
    logic [15:0] load_val = '0;
    logic irq_mreq = 0;
    logic [NW-1:0] irq_nm_req = '0;
    logic [15:0] ps_word;
    logic idx8_mode, data8_mode, dec_mode, irq_go;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        logic [15:0] val;
        logic [15:0] care;
        string       tag;
    } exp_t;
    exp_t sb[$];

    logic [10:0] m_val;
    logic [10:0] m_care;

    always #2.5 clk = ~clk;

    psr_status_reg #(.DATA_W(DW), .NM_W(NW)) i_psr_status_reg (
        .clk(clk), .rst_n(rst_n), .alu_nz_en(alu_nz_en), .alu_result(alu_result),
        .alu_c_en(alu_c_en), .alu_carry(alu_carry), .alu_v_en(alu_v_en), .alu_ovf(alu_ovf),
        .set_en(set_en), .clr_en(clr_en), .flag_mask(flag_mask), .sei_cmd(sei_cmd),
        .clc_cmd(clc_cmd), .irq_accept(irq_accept), .load_en(load_en), .load_val(load_val),
        .irq_mreq(irq_mreq), .irq_nm_req(irq_nm_req), .ps_word(ps_word),
        .idx8_mode(idx8_mode), .data8_mode(data8_mode), .dec_mode(dec_mode), .irq_go(irq_go)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Requirement model of one clock edge.
    task automatic model_edge();
        logic [10:0] n;
        logic [7:0] sv, cv;
        n = m_val;
        if (alu_nz_en) begin
            n[1] = m_val[5] ? (alu_result[7:0] == 0) : (alu_result == 0);
            n[7] = m_val[5] ? alu_result[7] : alu_result[15];
            m_care[1] = 1'b1;
        end
        if (alu_c_en) begin n[0] = alu_carry; m_care[0] = 1'b1; end
        if (alu_v_en) n[6] = alu_ovf;
        sv = set_en ? flag_mask : 8'h00;
        cv = clr_en ? flag_mask : 8'h00;
        if (sei_cmd) sv[2] = 1'b1;
        if (clc_cmd) cv[0] = 1'b1;
        for (int b = 0; b < 8; b++) begin
            if (cv[b]) n[b] = 1'b0;
            if (sv[b]) n[b] = 1'b1;
        end
        m_care[1:0] = m_care[1:0] | sv[1:0] | cv[1:0];
        if (irq_accept) n[2] = 1'b1;
        if (load_en) begin n = load_val[10:0]; m_care = '1; end
        m_val = n;
    endtask

    // One stimulus cycle: inputs already set at a falling edge.
    task automatic step(input string tag);
        exp_t e;
        model_edge();
        @(posedge clk);
        e.val = {5'b0, m_val};
        e.care = {5'h1f, m_care};
        e.tag = tag;
        sb.push_back(e);
        @(negedge clk);
        alu_nz_en = 0; alu_c_en = 0; alu_v_en = 0; alu_carry = 0; alu_ovf = 0;
        set_en = 0; clr_en = 0; sei_cmd = 0; clc_cmd = 0; irq_accept = 0; load_en = 0;
        flag_mask = '0; load_val = '0; alu_result = '0;
    endtask

    // Monitor: compare the status word against queued expectations.
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            check(e.tag, ps_word & e.care, e.val & e.care);
        end
    end

    task automatic gate_check(input string tag, input logic mreq, input logic [NW-1:0] nm);
        irq_mreq = mreq; irq_nm_req = nm;
        #1;
        check(tag, {15'b0, irq_go}, {15'b0, (mreq & ~m_val[2]) | (|nm)});
        irq_mreq = 0; irq_nm_req = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_val = 11'h004;
        m_care = 11'h7fc;
        begin exp_t e; e.val = 16'h0004; e.care = 16'hfffc; e.tag = "R2 reset"; sb.push_back(e); end
        @(negedge clk);
        #0.1;
        check("R9 modes after reset", {13'b0, idx8_mode, data8_mode, dec_mode}, 16'h0);
        gate_check("R8 masked at reset", 1'b1, '0);
        gate_check("R8 nmi class at reset", 1'b1, 4'b0010);

        set_en = 1; flag_mask = 8'hff; step("R4 set all");
        #0.1;
        check("R9 modes set", {13'b0, idx8_mode, data8_mode, dec_mode}, 16'h7);
        clr_en = 1; flag_mask = 8'h0f; step("R4 clear low nibble");
        gate_check("R8 maskable passes", 1'b1, '0);
        alu_nz_en = 1; alu_result = 16'h0100; step("R3 8-bit zero");
        clr_en = 1; flag_mask = 8'h20; step("R4 clear data-length");
        alu_nz_en = 1; alu_result = 16'h0100; step("R3 16-bit nonzero");
        alu_nz_en = 1; alu_result = 16'h8000; alu_c_en = 1; alu_carry = 1;
        alu_v_en = 1; alu_ovf = 1; step("R3 neg carry ovf");
        set_en = 1; clr_en = 1; flag_mask = 8'h09; alu_c_en = 1; alu_carry = 0; step("R4 set beats clear and ALU");
        clc_cmd = 1; alu_c_en = 1; alu_carry = 1; step("R5 clc");
        sei_cmd = 1; clr_en = 1; flag_mask = 8'h04; step("R5 sei over clear");
        clr_en = 1; flag_mask = 8'h04; step("R4 clear I");
        gate_check("R8 pass with I clear", 1'b1, '0);
        clr_en = 1; flag_mask = 8'h04; irq_accept = 1; step("R6 accept beats clear");
        gate_check("R8 blocked after accept", 1'b1, '0);
        gate_check("R8 watchdog class", 1'b0, 4'b0100);
        load_en = 1; load_val = 16'hffff; step("R1 R7 load all ones");
        load_en = 1; load_val = 16'h0500; irq_accept = 1; set_en = 1; flag_mask = 8'hff; step("R7 load beats accept");
        #0.1;
        check("R9 modes after load", {13'b0, idx8_mode, data8_mode, dec_mode}, 16'h0);
        gate_check("R8 maskable after load", 1'b1, '0);
        load_en = 1; load_val = 16'hf83a; step("R1 upper bits ignored");
        @(negedge clk);
        rst_n = 0;
        @(negedge clk);
        rst_n = 1;
        m_val[10:2] = 9'h001;
        begin exp_t e; e.val = 16'h0004; e.care = 16'hfffc; e.tag = "R2 second reset"; sb.push_back(e); end
        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule